// File: doc/BRIEF.md
# Dual-Clock Byte FIFO with Fixed-Offset Status Flags

This block buffers bytes between a producer and a consumer that run on separate clocks. The two clocks may be unrelated or may be the same net. The producer pulls its active-low write strobe low to push a byte on a write-clock rise. The consumer pulls its active-low read strobe low to pop the oldest byte into a registered output on a read-clock rise. An active-low output-enable input drives a separate bus-drive qualifier, so a pad ring or an internal mux can model a three-state bus without internal tri-states.

Four active-low status flags report occupancy. The empty and almost-empty flags are registered on the read clock. The full and almost-full flags are registered on the write clock. The partial flags trip at a fixed distance of seven words from each end. The pointers cross between domains in Gray code through multi-stage synchronizers. A flag is therefore raised on the very edge that causes its condition, and it is released a few cycles after the opposite side has moved.

Top module: `dcfifo_offset_flags`

## Requirements
- R1: While `rst_n` is low at rising edges of both clocks, both pointers return to the first location, `full_n` and `almost_full_n` read 1, `empty_n` and `almost_empty_n` read 0, and the output register (`rd_data`) reads 0x00.
- R2: On a `wr_clk` rise with `wr_en_n` = 0 and `full_n` = 1, `wr_data` is stored. When `full_n` = 0 the write is ignored: no word is lost and none is added.
- R3: On a `rd_clk` rise with `rd_en_n` = 0 and `empty_n` = 1, the oldest word appears on `rd_data` right after that edge. Otherwise `rd_data` keeps its previous value.
- R4: Words leave in the exact order in which they were accepted, with no loss or duplication, under any mix of reads and writes.
- R5: `full_n` falls on the write edge that stores the DEPTH-th word (the 64th at the default depth) and is 0 whenever DEPTH words are held.
- R6: `almost_full_n` is 0 whenever at least DEPTH-7 words are held. At the default depth with no reads it falls on the 57th write and is 1 after the 56th.
- R7: `empty_n` falls on the read edge that removes the last word and is 0 whenever no word is held.
- R8: `almost_empty_n` is 0 whenever 7 or fewer words are held. After the 8th word is present it reads 1 once the write pointer has crossed over.
- R9: Flags owned by one domain are released within SYNC_STAGES+2 of its own clock cycles after the opposite side's last operation. Once both sides are idle, the flags match the occupancy table: 0 words gives empty and almost-empty low; 1..7 gives almost-empty low; 8..DEPTH-8 gives all flags high; DEPTH-7..DEPTH-1 gives almost-full low; DEPTH gives full and almost-full low.
- R10: `rd_data_drive` is 1 when `out_en_n` is 0 and 0 when `out_en_n` is 1. `rd_data` always shows the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled by both clocks |
| wr_en_n | input | 1 | Active-low write strobe |
| wr_data | input | WIDTH (8) | Byte to store |
| rd_en_n | input | 1 | Active-low read strobe |
| out_en_n | input | 1 | Active-low output drive enable |
| rd_data | output | WIDTH (8) | Output register contents |
| rd_data_drive | output | 1 | High when the read bus should be driven |
| empty_n | output | 1 | Low when empty (read clock) |
| almost_empty_n | output | 1 | Low when 7 or fewer words (read clock) |
| almost_full_n | output | 1 | Low when DEPTH-7 or more words (write clock) |
| full_n | output | 1 | Low when full (write clock) |

## Verification
On every cycle, the embedded properties check several relations. A full buffer freezes the write pointer, and a blocked read freezes the output register. Each domain's own view of occupancy forces its flag low whenever the threshold is met. No view ever exceeds the depth. Only the bench scenarios can show the rest: the exact write count at which each write-side flag trips, the in-order data stream across unrelated clocks, and the release of flags after the far side moves, which depends on synchronizer latency and so is checked after idle windows against the occupancy table.

// File: rtl/dcfifo_pkg.sv
// Shared constants and flag bundles for the dual-clock FIFO.
// Assumes flags are active-low, as seen at the block's ports.
package dcfifo_pkg;

    // Distance of the partial flags from each end of the buffer
    localparam int unsigned EDGE_GAP = 7;

    // Flags owned by the write clock domain
    typedef struct packed {
        logic full_n;
        logic almost_full_n;
    } wr_flags_t;

    // Flags owned by the read clock domain
    typedef struct packed {
        logic empty_n;
        logic almost_empty_n;
    } rd_flags_t;

endpackage

// File: rtl/dcf_sync.sv
// Multi-stage synchronizer for a Gray-coded pointer.
// Assumes the input changes by at most one bit per source clock.
module dcf_sync #(
    parameter int unsigned W      = 7,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // One flop stage of the chain, cleared by reset
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else if (g == 0) stg[g] <= d;
                else stg[g] <= stg[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_wr_ctrl.sv
// Write-side pointer and flag logic for the dual-clock FIFO.
// Registers full and almost-full from the next-cycle occupancy, so both
// assert on the causing edge and release only after the read pointer arrives.
module dcf_wr_ctrl
    import dcfifo_pkg::*;
#(
    parameter int unsigned DEPTH       = 64,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned AW         = $clog2(DEPTH),
    localparam int unsigned PW         = AW + 1
) (
    input  logic          wr_clk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic [PW-1:0] rptr_gray_i,
    output logic [PW-1:0] wptr_gray_o,
    output logic [AW-1:0] waddr_o,
    output logic          wr_ok_o,
    output wr_flags_t     flags_o
);
    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
    localparam logic [PW-1:0] AF_CNT   = PW'(DEPTH - EDGE_GAP);

    logic [PW-1:0] wbin, wgray, rgray_s, rbin_s, used, used_nxt;
    wr_flags_t     flg;

    function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rsync (
        .clk(wr_clk), .rst_n(rst_n), .d(rptr_gray_i), .q(rgray_s)
    );

    // Occupancy seen from the write side, now and after this edge
    always_comb begin
        rbin_s   = gray2bin(rgray_s);
        used     = wbin - rbin_s;
        used_nxt = used + {{AW{1'b0}}, wr_ok_o};
    end

    assign wr_ok_o     = !wr_en_n && flg.full_n;
    assign wptr_gray_o = wgray;
    assign waddr_o     = wbin[AW-1:0];
    assign flags_o     = flg;

    // Advance the write pointer and register the write-side flags
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            wbin              <= '0;
            wgray             <= '0;
            flg.full_n        <= 1'b1;
            flg.almost_full_n <= 1'b1;
        end else begin
            if (wr_ok_o) begin
                wbin  <= wbin + 1'b1;
                wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
            end
            flg.full_n        <= (used_nxt != FULL_CNT);
            flg.almost_full_n <= (used_nxt < AF_CNT);
        end
    end

    // R2
    no_write_when_full_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !flg.full_n |=> $stable(wbin));
    // R5
    full_at_depth_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (used == FULL_CNT) |-> !flg.full_n);
    // R6
    af_at_threshold_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (used >= AF_CNT) |-> !flg.almost_full_n);
    // R4
    wr_view_bounded_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        used <= FULL_CNT);
endmodule

// File: rtl/dcf_rd_ctrl.sv
// Read-side pointer and flag logic for the dual-clock FIFO.
// Registers empty and almost-empty from the next-cycle occupancy, so both
// assert on the causing edge and release only after the write pointer arrives.
module dcf_rd_ctrl
    import dcfifo_pkg::*;
#(
    parameter int unsigned DEPTH       = 64,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned AW         = $clog2(DEPTH),
    localparam int unsigned PW         = AW + 1
) (
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          rd_en_n,
    input  logic [PW-1:0] wptr_gray_i,
    output logic [PW-1:0] rptr_gray_o,
    output logic [AW-1:0] raddr_o,
    output logic          rd_ok_o,
    output rd_flags_t     flags_o
);
    localparam logic [PW-1:0] AE_CNT   = PW'(EDGE_GAP);
    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

    logic [PW-1:0] rbin, rgray, wgray_s, wbin_s, used, used_nxt;
    rd_flags_t     flg;

    function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
        .clk(rd_clk), .rst_n(rst_n), .d(wptr_gray_i), .q(wgray_s)
    );

    // Occupancy seen from the read side, now and after this edge
    always_comb begin
        wbin_s   = gray2bin(wgray_s);
        used     = wbin_s - rbin;
        used_nxt = used - {{AW{1'b0}}, rd_ok_o};
    end

    assign rd_ok_o     = !rd_en_n && flg.empty_n;
    assign rptr_gray_o = rgray;
    assign raddr_o     = rbin[AW-1:0];
    assign flags_o     = flg;

    // Advance the read pointer and register the read-side flags
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rbin               <= '0;
            rgray              <= '0;
            flg.empty_n        <= 1'b0;
            flg.almost_empty_n <= 1'b0;
        end else begin
            if (rd_ok_o) begin
                rbin  <= rbin + 1'b1;
                rgray <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
            end
            flg.empty_n        <= (used_nxt != '0);
            flg.almost_empty_n <= (used_nxt > AE_CNT);
        end
    end

    // R7
    empty_at_zero_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (used == '0) |-> !flg.empty_n);
    // R8
    ae_at_threshold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (used <= AE_CNT) |-> !flg.almost_empty_n);
    // R4
    rd_view_bounded_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        used <= FULL_CNT);
endmodule

// File: rtl/dcfifo_offset_flags.sv
// Top of the dual-clock byte FIFO with fixed-offset partial flags.
// Holds the storage array (written on wr_clk, read into a registered output
// on rd_clk) and joins the two pointer controllers.
// Assumes DEPTH is a power of two, at least 16, and rst_n is held low for
// several cycles of both clocks.
module dcfifo_offset_flags
    import dcfifo_pkg::*;
#(
    parameter int unsigned DEPTH       = 64,
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned AW         = $clog2(DEPTH),
    localparam int unsigned PW         = AW + 1
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             wr_en_n,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en_n,
    input  logic             out_en_n,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_data_drive,
    output logic             empty_n,
    output logic             almost_empty_n,
    output logic             almost_full_n,
    output logic             full_n
);
    logic [PW-1:0]    wgray, rgray;
    logic [AW-1:0]    waddr, raddr;
    logic             wr_ok, rd_ok;
    wr_flags_t        wflg;
    rd_flags_t        rflg;
    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rd_q;

    dcf_wr_ctrl #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_wr (
        .wr_clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
        .rptr_gray_i(rgray), .wptr_gray_o(wgray), .waddr_o(waddr),
        .wr_ok_o(wr_ok), .flags_o(wflg)
    );

    dcf_rd_ctrl #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_rd (
        .rd_clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n),
        .wptr_gray_i(wgray), .rptr_gray_o(rgray), .raddr_o(raddr),
        .rd_ok_o(rd_ok), .flags_o(rflg)
    );

    // Store an accepted byte in the storage array
    always_ff @(posedge wr_clk) begin
        if (wr_ok) mem[waddr] <= wr_data;
    end

    // Load the output register on an accepted read, clear it on reset
    always_ff @(posedge rd_clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_ok) rd_q <= mem[raddr];
    end

    assign rd_data        = rd_q;
    assign rd_data_drive  = !out_en_n;
    assign empty_n        = rflg.empty_n;
    assign almost_empty_n = rflg.almost_empty_n;
    assign full_n         = wflg.full_n;
    assign almost_full_n  = wflg.almost_full_n;

    // R3
    out_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_en_n || !empty_n) |=> $stable(rd_q));
    // R9
    flag_order_wr_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |-> !almost_full_n);
    // R9
    flag_order_rd_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |-> !almost_empty_n);
endmodule

// File: tb/test_dcfifo_offset_flags.sv
`timescale 1ns/1ps
module test_dcfifo_offset_flags;
    localparam int DEPTH = 64;

    logic       wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic       wr_en_n = 1'b1, rd_en_n = 1'b1, out_en_n = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       rd_data_drive, empty_n, almost_empty_n, almost_full_n, full_n;

    int         n_chk = 0, n_fail = 0;
    logic [7:0] q [$];
    logic [7:0] last_out;
    logic       rd_pend;
    logic [7:0] rd_exp;
    int         wprob, rprob;

    always #2.5 wr_clk = ~wr_clk;   // 200 MHz write clock
    always #3.5 rd_clk = ~rd_clk;   // unrelated read clock

    dcfifo_offset_flags #(.DEPTH(DEPTH)) i_dcfifo_offset_flags (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n),
        .out_en_n(out_en_n), .rd_data(rd_data), .rd_data_drive(rd_data_drive),
        .empty_n(empty_n), .almost_empty_n(almost_empty_n),
        .almost_full_n(almost_full_n), .full_n(full_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic exp_full_n(input int n);      return n != DEPTH;      endfunction
    function automatic logic exp_af_n(input int n);        return n < DEPTH - 7;   endfunction
    function automatic logic exp_empty_n(input int n);     return n != 0;          endfunction
    function automatic logic exp_ae_n(input int n);        return n > 7;           endfunction

    task automatic settle();
        repeat (10) @(negedge wr_clk);
        repeat (10) @(negedge rd_clk);
    endtask

    // R9: idle flags against the occupancy table
    task automatic check_table(input string tag);
        int n = q.size();
        chk({"R9 full ", tag}, full_n, exp_full_n(n));
        chk({"R9 afull ", tag}, almost_full_n, exp_af_n(n));
        chk({"R9 empty ", tag}, empty_n, exp_empty_n(n));
        chk({"R9 aempty ", tag}, almost_empty_n, exp_ae_n(n));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en_n = 1'b1; rd_en_n = 1'b1;
        repeat (4) @(negedge rd_clk);
        q.delete();
        chk("R1 full_n", full_n, 1); chk("R1 almost_full_n", almost_full_n, 1);
        chk("R1 empty_n", empty_n, 0); chk("R1 almost_empty_n", almost_empty_n, 0);
        chk("R1 rd_data", rd_data, 8'h00);
        last_out = 8'h00;
        rst_n = 1'b1;
        repeat (2) @(negedge rd_clk);
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge wr_clk);
        wr_en_n = 1'b0; wr_data = v;
        if (full_n) q.push_back(v);
        @(negedge wr_clk);
        wr_en_n = 1'b1;
    endtask

    task automatic do_read();
        logic acc; logic [7:0] e;
        @(negedge rd_clk);
        rd_en_n = 1'b0;
        acc = empty_n;
        e = last_out;
        if (acc) e = q.pop_front();
        @(negedge rd_clk);
        rd_en_n = 1'b1;
        chk(acc ? "R3 R4 read data" : "R3 hold on empty", rd_data, e);
        last_out = e;
    endtask

    task automatic run_random(input int iters);
        fork
            begin
                for (int i = 0; i < iters; i++) begin
                    @(negedge wr_clk);
                    wr_en_n = ($urandom % 100) >= wprob;
                    wr_data = 8'($urandom);
                    if (!wr_en_n && full_n) begin
                        if (q.size() >= DEPTH) begin
                            n_chk++; n_fail++;
                            $display("FAIL R2: actual overflow size %0d expected <= %0d", q.size() + 1, DEPTH);
                        end
                        q.push_back(wr_data);
                    end
                end
                @(negedge wr_clk); wr_en_n = 1'b1;
            end
            begin
                rd_pend = 1'b0;
                for (int i = 0; i < iters; i++) begin
                    @(negedge rd_clk);
                    if (rd_pend) begin chk("R4 random order", rd_data, rd_exp); last_out = rd_exp; end
                    rd_en_n = ($urandom % 100) >= rprob;
                    rd_pend = !rd_en_n && empty_n;
                    if (rd_pend) begin
                        if (q.size() == 0) begin
                            n_chk++; n_fail++;
                            $display("FAIL R7: actual read on empty expected blocked");
                            rd_pend = 1'b0;
                        end else rd_exp = q.pop_front();
                    end
                end
                @(negedge rd_clk); rd_en_n = 1'b1;
                if (rd_pend) begin chk("R4 random order", rd_data, rd_exp); last_out = rd_exp; end
            end
        join
    endtask

    initial begin
        void'($urandom(32'd1357));
        do_reset();
        chk("R10 drive on", rd_data_drive, 1);

        // Fill one word at a time, watching the empty-side flags cross over
        for (int k = 1; k <= DEPTH; k++) begin
            do_write(8'(k + 8'h20));
            chk($sformatf("R6 afull after write %0d", k), almost_full_n, (k < 57));
            chk($sformatf("R5 full after write %0d", k), full_n, (k != DEPTH));
            if (k == 1 || k == 7 || k == 8) begin
                settle();
                chk($sformatf("R7 empty_n at %0d", k), empty_n, 1);
                chk($sformatf("R8 aempty_n at %0d", k), almost_empty_n, (k >= 8));
            end
        end

        // Write while full is ignored
        do_write(8'hEE);
        chk("R2 size after blocked write", q.size(), DEPTH);
        settle();
        check_table("full");

        // Drain with immediate read-side flag assertion
        for (int k = 1; k <= DEPTH; k++) begin
            do_read();
            chk($sformatf("R8 aempty after read %0d", k), almost_empty_n, (DEPTH - k > 7));
            chk($sformatf("R7 empty after read %0d", k), empty_n, (k != DEPTH));
        end
        do_read();   // read on empty keeps last value
        settle();
        check_table("drained");

        // Output drive qualifier
        out_en_n = 1'b1; #1;
        chk("R10 drive off", rd_data_drive, 0);
        chk("R10 data still visible", rd_data, last_out);
        out_en_n = 1'b0; #1;
        chk("R10 drive back on", rd_data_drive, 1);

        // Random traffic: fill-heavy, drain-heavy, balanced
        wprob = 80; rprob = 30; run_random(3000); settle(); check_table("fill-heavy");
        wprob = 25; rprob = 85; run_random(3000); settle(); check_table("drain-heavy");
        wprob = 60; rprob = 60; run_random(3000); settle(); check_table("balanced");

        // Reset in the middle of traffic
        wprob = 90; rprob = 5; run_random(200);
        do_reset();
        settle();
        check_table("after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #900000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule